// File: doc/BRIEF.md
# Framed 26-Bit Word Serializer

This block takes parallel words from a slower strobe domain and sends them out one bit per clock on a serial line that never stops. The clock is the bit clock, which runs at 26 times the reference rate, so each reference period holds exactly one 26-bit frame. A frame starts with two word-boundary bits and ends with a 24-bit payload sent least significant bit first. A frame-marker output stays high during the boundary bits so that a receiver can find the word edges. Only 22 data bits are carried. The two top payload positions always go out as zero.

The strobe is asynchronous to the bit clock. It passes through a two-flop synchronizer, and its rising edge is detected in the bit-clock domain. On that edge the parallel input is copied into a single-entry holding register. At the start of every frame the state machine takes the held word if one is waiting. If none is waiting, it sends an all-zero payload, so the link keeps running whenever the strobe is slower than the reference. If a second word is captured while the holding register is still full, the new word is dropped and a sticky overflow flag is set.

Serialization starts only when the lock input is high. While lock is low the line stays quiet, strobes are ignored and any held word is discarded. The state machine has three states. WAIT is the unlocked, quiet state. MARK sends the boundary bits and BODY sends the payload. It has four named transitions. START goes from WAIT to MARK when lock is high and launches a frame. BODY_GO goes from MARK to BODY after the second boundary bit. NEXT goes from BODY to MARK after the 24th payload bit and launches the next frame. ABORT goes from any state to WAIT when lock is low.

Top module: `framed_word_serializer`

## Requirements
- R1: During and after reset, `ser_out`, `frame_mark` and `overflow` are all 0 until lock is asserted.
- R2: While `lock` is low, `ser_out` and `frame_mark` stay 0, strobes are not captured and any held word is discarded. The first frame after lock rises therefore carries a zero payload, even if strobes arrived while unlocked.
- R3: Each frame is 26 bit times long. The first two bits are the boundary bits, sent as 1 and then 0, with `frame_mark` high. The next 24 bits are the payload, with `frame_mark` low. While lock stays high, frames follow each other with no gap.
- R4: The payload goes out least significant bit first: payload bit j (j = 0..23) appears in bit time 2+j of the frame.
- R5: Payload bits 22 and 23 are always 0, whatever the input. Input bit `word_in[i]` maps to payload bit i for i = 0..21.
- R6: The value of `word_in` at a rising edge of `strobe` is captured within 4 clocks of that edge and is sent in the next frame that starts after the capture. `word_in` must stay stable during those 4 clocks.
- R7: A frame that starts with no word held carries an all-zero payload, and the boundary bits are still sent.
- R8: A capture while a word is already held, and that word is not being taken in the same cycle, drops the new word, keeps the held one for the next frame and sets `overflow`. `overflow` stays high until reset.
- R9: Dropping `lock` in the middle of a frame stops the output at once and discards any held word. When lock rises again, frames restart from the first boundary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (26 times the reference rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Clock source ready; enables framing and capture |
| strobe | input | 1 | Asynchronous capture strobe, rising edge active |
| word_in | input | 22 | Parallel data word |
| ser_out | output | 1 | Serial data line |
| frame_mark | output | 1 | High during the two boundary bits of each frame |
| overflow | output | 1 | Sticky flag: a capture was dropped because the holding register was full |

## Verification
The bench builds the block with its default parameters: 22 data bits, a 24-bit payload, two boundary bits and a two-stage synchronizer. With these values each frame is short enough for the bench to place one or two strobes inside a single frame at a random offset. This makes idle padding, the zeroed top payload bits and the overflow-drop path all reachable in a few hundred cycles. Random words and random choices to strobe or skip a frame are mixed with directed cases: all-ones, a single low bit, a double strobe, strobes while unlocked, and losing lock in the middle of a frame.

// File: rtl/fser_pkg.sv
package fser_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_MARK = 2'd1,
        ST_BODY = 2'd2
    } fser_state_e;

endpackage

// File: rtl/fser_strobe_sync.sv
module fser_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_rise
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= strobe_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign strobe_rise = chain_q[STAGES-1] & ~last_q;

    // R6: an edge pulse lasts a single clock
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !strobe_rise);

endmodule

// File: rtl/fser_hold.sv
module fser_hold #(
    parameter int PAYLOAD_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 capture,
    input  logic [PAYLOAD_W-1:0] word_d,
    input  logic                 take,
    output logic                 valid,
    output logic [PAYLOAD_W-1:0] word_q,
    output logic                 overflow
);

    logic                 valid_q;
    logic [PAYLOAD_W-1:0] data_q;
    logic                 ovf_q;
    logic                 cap_ok;
    logic                 cap_drop;

    assign cap_ok   = lock && capture && (!valid_q || take);
    assign cap_drop = lock && capture && valid_q && !take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (!lock) begin
            valid_q <= 1'b0;
        end else if (cap_ok) begin
            valid_q <= 1'b1;
            data_q  <= word_d;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (cap_drop) ovf_q <= 1'b1;
    end

    assign valid    = valid_q;
    assign word_q   = data_q;
    assign overflow = ovf_q;

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && capture && valid && !take) |=> (overflow && valid && word_q == $past(word_q)));

    p_unlocked_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> !valid);

endmodule

// File: rtl/fser_frame_fsm.sv
module fser_frame_fsm
    import fser_pkg::*;
#(
    parameter int                PAYLOAD_W = 24,
    parameter int                DATA_W    = 22,
    parameter int                BOUND_W   = 2,
    parameter logic [BOUND_W-1:0] BOUND_PAT = 2'b01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 hold_valid,
    input  logic [PAYLOAD_W-1:0] hold_word,
    output logic                 take,
    output logic                 ser_out,
    output logic                 frame_mark
);

    localparam int MAXC  = (PAYLOAD_W > BOUND_W) ? PAYLOAD_W : BOUND_W;
    localparam int CNT_W = $clog2(MAXC);
    localparam logic [CNT_W-1:0] BOUND_LAST = CNT_W'(BOUND_W - 1);
    localparam logic [CNT_W-1:0] BODY_LAST  = CNT_W'(PAYLOAD_W - 1);
    localparam logic [CNT_W-1:0] DATA_TOP   = CNT_W'(DATA_W);

    fser_state_e          state_q, state_n;
    logic [CNT_W-1:0]     cnt_q, cnt_n;
    logic [PAYLOAD_W-1:0] shreg_q;
    logic                 live_q;
    logic                 bound_bit;

    // next-state logic: START, BODY_GO, NEXT, ABORT
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q + 1'b1;
        unique case (state_q)
            ST_WAIT: begin
                cnt_n = '0;
                if (lock) state_n = ST_MARK;
            end
            ST_MARK: begin
                if (cnt_q == BOUND_LAST) begin
                    state_n = ST_BODY;
                    cnt_n   = '0;
                end
            end
            ST_BODY: begin
                if (cnt_q == BODY_LAST) begin
                    state_n = ST_MARK;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_WAIT;
                cnt_n   = '0;
            end
        endcase
        if (!lock) begin
            state_n = ST_WAIT;
            cnt_n   = '0;
        end
    end

    assign take = (state_n == ST_MARK) && (cnt_n == '0) &&
                  ((state_q == ST_WAIT) || (state_q == ST_BODY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // payload shifter, loaded at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            live_q  <= 1'b0;
        end else if (take) begin
            shreg_q <= hold_valid ? hold_word : '0;
            live_q  <= hold_valid;
        end else if (state_q == ST_BODY) begin
            shreg_q <= {1'b0, shreg_q[PAYLOAD_W-1:1]};
        end
    end

    always_comb begin
        bound_bit = 1'b0;
        for (int b = 0; b < BOUND_W; b++) begin
            if (cnt_q == CNT_W'(b)) bound_bit = BOUND_PAT[b];
        end
    end

    // output process
    always_comb begin
        ser_out    = 1'b0;
        frame_mark = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                ser_out    = 1'b0;
                frame_mark = 1'b0;
            end
            ST_MARK: begin
                ser_out    = bound_bit;
                frame_mark = 1'b1;
            end
            ST_BODY: begin
                ser_out    = shreg_q[0];
                frame_mark = 1'b0;
            end
            default: begin
                ser_out    = 1'b0;
                frame_mark = 1'b0;
            end
        endcase
    end

    p_quiet_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> (!ser_out && !frame_mark));

    p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && cnt_q == BODY_LAST && lock) |=> (frame_mark && cnt_q == '0));

    p_mark_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_mark) && lock) |=> frame_mark);

    p_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && cnt_q >= DATA_TOP) |-> !ser_out);

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && !live_q) |-> !ser_out);

endmodule

// File: rtl/framed_word_serializer.sv
module framed_word_serializer #(
    parameter int                DATA_W      = 22,
    parameter int                PAYLOAD_W   = 24,
    parameter int                BOUND_W     = 2,
    parameter logic [BOUND_W-1:0] BOUND_PAT   = 2'b01,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              strobe,
    input  logic [DATA_W-1:0] word_in,
    output logic              ser_out,
    output logic              frame_mark,
    output logic              overflow
);

    localparam int PAD_W = PAYLOAD_W - DATA_W;

    logic                 rise;
    logic                 take;
    logic                 hold_valid;
    logic [PAYLOAD_W-1:0] hold_word;
    logic [PAYLOAD_W-1:0] wide_word;

    assign wide_word = {{PAD_W{1'b0}}, word_in};

    fser_strobe_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_async(strobe),
        .strobe_rise (rise)
    );

    fser_hold #(
        .PAYLOAD_W(PAYLOAD_W)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (lock),
        .capture (rise),
        .word_d  (wide_word),
        .take    (take),
        .valid   (hold_valid),
        .word_q  (hold_word),
        .overflow(overflow)
    );

    fser_frame_fsm #(
        .PAYLOAD_W(PAYLOAD_W),
        .DATA_W   (DATA_W),
        .BOUND_W  (BOUND_W),
        .BOUND_PAT(BOUND_PAT)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .hold_valid(hold_valid),
        .hold_word (hold_word),
        .take      (take),
        .ser_out   (ser_out),
        .frame_mark(frame_mark)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !$past(lock)) |-> (!ser_out && !frame_mark));

endmodule

// File: tb/test_framed_word_serializer.sv
module test_framed_word_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock = 1'b0;
    logic        strobe = 1'b0;
    logic [21:0] word_in = '0;
    logic        ser_out;
    logic        frame_mark;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    framed_word_serializer i_framed_word_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .strobe    (strobe),
        .word_in   (word_in),
        .ser_out   (ser_out),
        .frame_mark(frame_mark),
        .overflow  (overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_payload(input bit had, input logic [21:0] w);
        return had ? {2'b00, w} : 24'h0;
    endfunction

    // Reads one frame; optionally strobes one or two words at bit offset off.
    task automatic read_frame(input int nstb, input logic [21:0] w1, input logic [21:0] w2,
                              input int off, output logic [23:0] pay, output int gap,
                              output int bad_mark, output logic [1:0] bnd);
        logic [25:0] bits;
        gap = 0;
        bad_mark = 0;
        @(negedge clk);
        while (!frame_mark) begin
            gap++;
            @(negedge clk);
        end
        for (int i = 0; i < 26; i++) begin
            if (i > 0) @(negedge clk);
            bits[i] = ser_out;
            if (frame_mark !== (i < 2)) bad_mark++;
            if (nstb >= 1 && i == off)     begin strobe = 1'b1; word_in = w1; end
            if (nstb >= 1 && i == off + 3)  strobe = 1'b0;
            if (nstb >= 2 && i == off + 6) begin strobe = 1'b1; word_in = w2; end
            if (nstb >= 2 && i == off + 9)  strobe = 1'b0;
        end
        pay = bits[25:2];
        bnd = bits[1:0];
    endtask

    logic [23:0] pay;
    int          gap, bm;
    logic [1:0]  bnd;
    bit          had;
    logic [21:0] prev_w;

    // Drives one frame with stimulus and checks it against the pending expectation.
    task automatic step(input string req, input int nstb, input logic [21:0] w1,
                        input logic [21:0] w2, input int off, input bit first);
        read_frame(nstb, w1, w2, off, pay, gap, bm, bnd);
        check({req, " payload"}, {8'h0, pay}, {8'h0, expect_payload(had, prev_w)});
        check("R3 boundary", {30'h0, bnd}, 32'h1);
        check("R3 marker", bm, 0);
        if (!first) check("R3 gap", gap, 0);
        had = (nstb >= 1);
        prev_w = w1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        had = 1'b0;
        prev_w = '0;

        repeat (3) @(negedge clk);
        check("R1 ser_out in reset", {31'h0, ser_out}, 0);
        check("R1 mark in reset", {31'h0, frame_mark}, 0);
        check("R1 overflow in reset", {31'h0, overflow}, 0);
        rst_n = 1'b1;

        // R2: strobes while unlocked must be ignored and line stays quiet
        begin
            int act = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (i % 10 == 2) begin strobe = 1'b1; word_in = 22'h2AAAAA; end
                if (i % 10 == 6) strobe = 1'b0;
                if (ser_out || frame_mark) act++;
            end
            check("R2 quiet while unlocked", act, 0);
            check("R1 overflow after reset", {31'h0, overflow}, 0);
        end

        lock = 1'b1;
        // R2/R7: first frame after lock carries zero payload
        step("R2 first frame zero", 1, 22'h3FFFFF, 22'h0, 4, 1'b1);
        // R5: all-ones input -> top two payload bits zero
        step("R5 all ones", 1, 22'h000001, 22'h0, 7, 1'b0);
        // R4: single low bit first
        step("R4 lsb first", 1, 22'h200000, 22'h0, 10, 1'b0);
        step("R6 msb data bit", 0, 22'h0, 22'h0, 0, 1'b0);
        // R7: idle frame pads with zeros
        step("R7 idle pad", 0, 22'h0, 22'h0, 0, 1'b0);

        // R6: random capture and idle mix
        for (int k = 0; k < 40; k++) begin
            int n = ($urandom % 3 == 0) ? 0 : 1;
            step("R6 random", n, 22'($urandom), 22'h0, 2 + int'($urandom % 11), 1'b0);
        end
        check("R8 no overflow yet", {31'h0, overflow}, 0);

        // R8: two captures in one frame, the second is dropped
        step("R6 before double", 2, 22'h155555, 22'h0ABCDE, 3, 1'b0);
        check("R8 overflow set", {31'h0, overflow}, 1);
        step("R8 first word kept", 0, 22'h0, 22'h0, 0, 1'b0);
        check("R8 overflow sticky", {31'h0, overflow}, 1);

        // R9: drop lock mid-frame with a word pending
        step("R9 pre", 1, 22'h3C3C3C, 22'h0, 2, 1'b0);
        repeat (10) @(negedge clk);
        lock = 1'b0;
        begin
            int act = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (i == 5) begin strobe = 1'b1; word_in = 22'h111111; end
                if (i == 9) strobe = 1'b0;
                if (ser_out || frame_mark) act++;
            end
            check("R9 quiet after lock loss", act, 0);
        end
        lock = 1'b1;
        had = 1'b0;
        step("R9 restart zero", 1, 22'h0F0F0F, 22'h0, 5, 1'b1);
        step("R9 resumed data", 0, 22'h0, 22'h0, 0, 1'b0);
        check("R8 overflow still set", {31'h0, overflow}, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule